// File: doc/BRIEF.md
# Power-Up Stability Evaluator

This block grades how reliably a chosen group of SRAM cells settles to the same value at power-up. External logic reads the cells back after each power cycle and streams the results into the block, one beat per cell. Each beat carries a cell address and the bit read there, and the last beat of a readout pass is marked. Only addresses entered in a small selection table are evaluated. Any other address is tallied as a stray reading.

A start command opens a run and sets the number of passes. The first pass records a reference bit for every selected cell. Every later pass compares each reading against that reference. A cell that disagrees even once is marked unstable, and the mark stays until the next start. When the last pass has been fully streamed, the block counts the unstable cells among the selected ones. A bit-serial divider then converts that count into parts per million of the selected population. A done flag signals that these results are ready.

Top module: `psm_stability_eval`

## Requirements
- R1: A start pulse clears every unstable mark, the stray-reading count and the done flag, and latches `pass_count` as the number of passes in the run. A value of 0 is treated as 1. A start takes priority over a reading presented in the same cycle.
- R2: A table write with `sel_keep`=1 puts `sel_addr` into slot `sel_idx` as a selected cell. With `sel_keep`=0 the write removes that slot. `sel_count` always equals the number of occupied slots.
- R3: During the first pass of a run (pass index 0), a reading of a selected address stores that bit as the cell's reference and marks nothing.
- R4: During any later pass, a reading of a selected address whose bit differs from the stored reference marks the cell unstable. The mark stays set through later matching readings until the next start.
- R5: While a run is active, a reading whose address is not in the table adds one to `err_count`, which saturates at 65535. Such a reading changes no mark.
- R6: Readings presented while no run is active (before the first start, or after done) change neither `err_count` nor any result.
- R7: A pass ends on the beat that has both `rd_valid` and `rd_last` high. After the latched number of passes, `done` rises. A mismatch carried on that final beat is included in the result.
- R8: At done, `unstable_count` equals the number of selected cells that are marked unstable.
- R9: At done, `ppm` equals floor(`unstable_count` × 1000000 / `sel_count`). When `sel_count` is 0, `ppm` is 0.
- R10: `done` and all results stay unchanged until the next start. A start issued during a run abandons that run and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the selection table |
| sel_idx | input | IDX_W (4) | Table slot to write |
| sel_addr | input | ADDR_W (16) | Cell address for the slot |
| sel_keep | input | 1 | 1 = slot holds a selected cell, 0 = slot emptied |
| start | input | 1 | Begin a run |
| pass_count | input | 16 | Number of passes in the run, sampled on start |
| rd_valid | input | 1 | Readout beat valid |
| rd_addr | input | ADDR_W (16) | Address of the cell read |
| rd_bit | input | 1 | Power-up value of that cell |
| rd_last | input | 1 | Beat is the final one of the pass |
| done | output | 1 | Results valid |
| sel_count | output | CNT_W (5) | Number of selected cells |
| unstable_count | output | CNT_W (5) | Selected cells marked unstable |
| err_count | output | 16 | Readings of unselected addresses in this run |
| ppm | output | 20 | Unstable fraction in parts per million |

## Verification
The last beat of the final pass does two things in the same cycle: it updates that cell's unstable mark, and it closes the run, which hands the counts to the divider. The bench makes the final beat of the last pass carry a flipped bit. It then expects that cell to appear in `unstable_count` and in the ratio. A second collision arises when a start lands in the middle of a run. The bench restarts a run after a mismatch has been marked and expects a clean result from the new run.

// File: rtl/psm_pkg.sv
package psm_pkg;

    localparam int PPM_SCALE = 1000000;
    localparam int PPM_W     = 20;
    localparam int PASS_W    = 16;
    localparam int ERR_W     = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_LOAD,
        ST_DIV,
        ST_DONE
    } psm_state_e;

    function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] v);
        return (v == '1) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/psm_sel_table.sv
module psm_sel_table #(
    parameter int NSEL   = 16,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_keep,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [NSEL-1:0]   valid_vec,
    output logic [CNT_W-1:0]  count
);
    logic [ADDR_W-1:0] slot_addr [NSEL];
    logic [NSEL-1:0]   slot_vld;
    logic [NSEL-1:0]   match;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
            for (int i = 0; i < NSEL; i++) slot_addr[i] <= '0;
        end else if (wr && (int'(wr_idx) < NSEL)) begin
            slot_vld[wr_idx]  <= wr_keep;
            slot_addr[wr_idx] <= wr_addr;
        end
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_cmp
        assign match[g] = slot_vld[g] && (slot_addr[g] == look_addr);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSEL - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < NSEL; i++) count = count + CNT_W'(slot_vld[i]);
    end

    assign valid_vec = slot_vld;
endmodule

// File: rtl/psm_cell_track.sv
module psm_cell_track #(
    parameter int NSEL  = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic             ref_pass,
    input  logic [IDX_W-1:0] idx,
    input  logic             bit_in,
    input  logic [NSEL-1:0]  valid_vec,
    output logic [CNT_W-1:0] unstable_now
);
    logic [NSEL-1:0] ref_q;
    logic [NSEL-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            flag_q <= '0;
        end else if (clr) begin
            flag_q <= '0;
        end else if (upd) begin
            if (ref_pass)
                ref_q[idx] <= bit_in;
            else if (bit_in != ref_q[idx])
                flag_q[idx] <= 1'b1;
        end
    end

    always_comb begin
        unstable_now = '0;
        for (int i = 0; i < NSEL; i++)
            unstable_now = unstable_now + CNT_W'(flag_q[i] & valid_vec[i]);
    end
endmodule

// File: rtl/psm_ppm_div.sv
module psm_ppm_div #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 5,
    parameter int Q_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [Q_W-1:0]   quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  sh_q;
    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] left_q;
    logic [DEN_W:0]    trial;
    logic              take;

    assign trial = {rem_q, sh_q[NUM_W-1]};
    assign take  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            quo    <= '0;
        end else if (load) begin
            sh_q   <= num;
            rem_q  <= '0;
            den_q  <= den;
            quo    <= '0;
            left_q <= (den == '0) ? '0 : STEP_W'(NUM_W);
        end else if (left_q != '0) begin
            sh_q   <= sh_q << 1;
            rem_q  <= take ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
            quo    <= {quo[Q_W-2:0], take};
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/psm_stability_eval.sv
module psm_stability_eval
    import psm_pkg::*;
#(
    parameter int NSEL   = 16,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = (NSEL > 1) ? $clog2(NSEL) : 1,
    parameter int CNT_W  = $clog2(NSEL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              sel_keep,
    input  logic              start,
    input  logic [15:0]       pass_count,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_bit,
    input  logic              rd_last,
    output logic              done,
    output logic [CNT_W-1:0]  sel_count,
    output logic [CNT_W-1:0]  unstable_count,
    output logic [15:0]       err_count,
    output logic [19:0]       ppm
);
    localparam int NUM_W = CNT_W + PPM_W;

    psm_state_e        state_q;
    logic [PASS_W-1:0] target_q;
    logic [PASS_W-1:0] pass_q;
    logic [ERR_W-1:0]  err_q;
    logic [CNT_W-1:0]  unst_q;
    logic [PPM_W-1:0]  ppm_q;

    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [NSEL-1:0]   valid_vec;
    logic [CNT_W-1:0]  unstable_now;
    logic              beat;
    logic              div_busy;
    logic [PPM_W-1:0]  div_quo;
    logic [NUM_W-1:0]  div_num;

    assign beat    = (state_q == ST_RUN) && rd_valid && !start;
    assign div_num = NUM_W'(unstable_now) * NUM_W'(PPM_SCALE);

    psm_sel_table #(.NSEL(NSEL), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst(rst), .wr(sel_wr), .wr_idx(sel_idx), .wr_addr(sel_addr),
        .wr_keep(sel_keep), .look_addr(rd_addr), .hit(hit), .hit_idx(hit_idx),
        .valid_vec(valid_vec), .count(sel_count)
    );

    psm_cell_track #(.NSEL(NSEL), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .clr(start), .upd(beat && hit),
        .ref_pass(pass_q == '0), .idx(hit_idx), .bit_in(rd_bit),
        .valid_vec(valid_vec), .unstable_now(unstable_now)
    );

    psm_ppm_div #(.NUM_W(NUM_W), .DEN_W(CNT_W), .Q_W(PPM_W)) u_div (
        .clk(clk), .rst(rst), .load(state_q == ST_LOAD && !start),
        .num(div_num), .den(sel_count), .busy(div_busy), .quo(div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            target_q <= PASS_W'(1);
            pass_q   <= '0;
            err_q    <= '0;
            unst_q   <= '0;
            ppm_q    <= '0;
        end else if (start) begin
            state_q  <= ST_RUN;
            target_q <= (pass_count == '0) ? PASS_W'(1) : pass_count;
            pass_q   <= '0;
            err_q    <= '0;
            unst_q   <= '0;
            ppm_q    <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (beat) begin
                        if (!hit) err_q <= sat_inc(err_q);
                        if (rd_last) begin
                            if (pass_q + 1'b1 == target_q) state_q <= ST_LOAD;
                            else                           pass_q  <= pass_q + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    unst_q  <= unstable_now;
                    state_q <= ST_DIV;
                end
                ST_DIV: begin
                    if (!div_busy) begin
                        ppm_q   <= div_quo;
                        state_q <= ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done           = (state_q == ST_DONE);
    assign unstable_count = unst_q;
    assign err_count      = err_q;
    assign ppm            = ppm_q;
endmodule

// File: rtl/psm_stability_eval_chk.sv
module psm_stability_eval_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [CNT_W-1:0] unstable_count,
    input logic [15:0]      err_count,
    input logic [19:0]      ppm
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && err_count == 16'd0)); // R1

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R10

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> ($stable(err_count) && $stable(unstable_count) && $stable(ppm))); // R6

    AST_PPM_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (ppm <= 20'd1000000)); // R9

    AST_PPM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && unstable_count == '0) |-> (ppm == 20'd0)); // R9

    AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !start |=> (err_count >= $past(err_count))); // R5
endmodule

bind psm_stability_eval psm_stability_eval_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .unstable_count(unstable_count), .err_count(err_count), .ppm(ppm)
);

// File: tb/psm_stability_eval_test.sv
module psm_stability_eval_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_wr = 1'b0;
    logic [3:0]  sel_idx = '0;
    logic [15:0] sel_addr = '0;
    logic        sel_keep = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pass_count = '0;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_bit = 1'b0;
    logic        rd_last = 1'b0;
    logic        done;
    logic [4:0]  sel_count;
    logic [4:0]  unstable_count;
    logic [15:0] err_count;
    logic [19:0] ppm;

    int n_chk = 0;
    int n_bad = 0;
    localparam logic [7:0] BASE = 8'b1011_0010;

    always #2.5 clk = ~clk;

    psm_stability_eval uut (
        .clk(clk), .rst(rst), .sel_wr(sel_wr), .sel_idx(sel_idx), .sel_addr(sel_addr),
        .sel_keep(sel_keep), .start(start), .pass_count(pass_count), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_bit(rd_bit), .rd_last(rd_last), .done(done),
        .sel_count(sel_count), .unstable_count(unstable_count), .err_count(err_count), .ppm(ppm)
    );

    function automatic logic [15:0] cell_addr(input int i);
        return 16'h0100 + 16'(i * 37);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tbl_write(input int idx, input logic [15:0] a, input logic keep);
        @(negedge clk);
        sel_wr = 1'b1; sel_idx = 4'(idx); sel_addr = a; sel_keep = keep;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic run_start(input int n);
        @(negedge clk);
        start = 1'b1; pass_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic beat(input logic [15:0] a, input logic b, input logic last);
        rd_valid = 1'b1; rd_addr = a; rd_bit = b; rd_last = last;
        @(negedge clk);
        rd_valid = 1'b0; rd_last = 1'b0;
    endtask

    // One pass over the eight table cells, optional stray reading first
    task automatic send_pass(input logic [7:0] bits, input logic stray);
        @(negedge clk);
        if (stray) beat(16'hFFF0, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) beat(cell_addr(i), bits[i], i == 7);
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check(req, done, 1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset done", done, 0);
        check("R2 reset sel_count", sel_count, 0);
        check("R5 reset err_count", err_count, 0);
        // R6: readings before any start are ignored
        beat(16'hFFF0, 1'b1, 1'b1);
        @(negedge clk);
        check("R6 idle reading", err_count, 0);
    endtask

    task automatic t_load_table;
        for (int i = 0; i < 8; i++) tbl_write(i, cell_addr(i), 1'b1);
        @(negedge clk);
        check("R2 eight selected", sel_count, 8);
    endtask

    task automatic t_main_run;
        run_start(5);
        send_pass(BASE, 1'b0);
        send_pass(BASE ^ 8'h04, 1'b1);   // R4 cell 2 flips once
        send_pass(BASE, 1'b0);           // R4 returns, mark stays
        send_pass(BASE, 1'b0);
        check("R7 not done before last pass", done, 0);
        send_pass(BASE ^ 8'h80, 1'b0);   // R7 flip on the closing beat
        wait_done("R7 done after five passes");
        check("R8 unstable count", unstable_count, 2);
        check("R9 ppm 2 of 8", ppm, 250000);
        check("R5 stray counted", err_count, 1);
    endtask

    task automatic t_after_done;
        send_pass(~BASE, 1'b1);
        @(negedge clk);
        check("R10 done held", done, 1);
        check("R6 err frozen", err_count, 1);
        check("R6 unstable frozen", unstable_count, 2);
    endtask

    task automatic t_clean_run;
        run_start(3);
        check("R1 start clears done", done, 0);
        check("R1 start clears err", err_count, 0);
        send_pass(BASE, 1'b0);
        send_pass(BASE, 1'b0);
        send_pass(BASE, 1'b0);
        wait_done("R7 three passes");
        check("R1 marks cleared", unstable_count, 0);
        check("R9 ppm zero", ppm, 0);
    endtask

    task automatic t_zero_passes;
        run_start(0);
        send_pass(~BASE, 1'b0);          // R3 reference pass only
        wait_done("R1 zero means one pass");
        check("R3 reference pass marks nothing", unstable_count, 0);
    endtask

    task automatic t_restart;
        run_start(4);
        send_pass(BASE, 1'b0);
        send_pass(BASE ^ 8'h02, 1'b0);
        run_start(2);                    // R10 abandon and restart
        send_pass(BASE, 1'b0);
        check("R10 restarted run not done", done, 0);
        send_pass(BASE, 1'b0);
        wait_done("R10 restarted run done");
        check("R10 restart clears marks", unstable_count, 0);
    endtask

    task automatic t_removed_slot;
        tbl_write(3, cell_addr(3), 1'b0);
        @(negedge clk);
        check("R2 slot removed", sel_count, 7);
        run_start(2);
        send_pass(BASE, 1'b0);
        send_pass(BASE ^ 8'h09, 1'b0);   // cell 0 flips, cell 3 unselected
        wait_done("R7 two passes");
        check("R5 unselected cell counted", err_count, 2);
        check("R8 removed cell not marked", unstable_count, 1);
        check("R9 ppm 1 of 7", ppm, 142857);
    endtask

    task automatic t_empty_table;
        for (int i = 0; i < 8; i++) tbl_write(i, cell_addr(i), 1'b0);
        @(negedge clk);
        check("R2 empty table", sel_count, 0);
        run_start(1);
        send_pass(BASE, 1'b0);
        wait_done("R7 empty run");
        check("R9 zero divisor", ppm, 0);
        check("R5 all stray", err_count, 8);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_table();
                t_main_run();
                t_after_done();
                t_clean_run();
                t_zero_passes();
                t_restart();
                t_removed_slot();
                t_empty_table();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule